// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Mode

This block buffers data words between two clock domains whose clocks have no fixed relation. One port writes words on its own clock and the other port reads them on its own clock. Each port has three strobes: a select, a direction bit and an enable. An access takes place only when all three are high. The write and read pointers cross between the domains in Gray code through a chain of flip-flops. Every status flag is therefore a function of registers in the domain that uses it.

A static mode input picks one of two read behaviours. The input is held steady while reset is active.

- In fall-through mode (mode input high), the oldest word moves into the output register by itself. The read-side flag then means "the output register holds a fresh word", and a read consumes that word.
- In standard mode (mode input low), the read-side flag means "memory holds a word". A read loads that word into the output register on the accepting edge.

The write-side flag means "a location is free" in both modes.

Top module: `xclk_fifo`

## Requirements
- R1: While `arst_n` is low, `r_flag` is 0 and `w_flag` is 1, in either mode.
- R2: In standard mode (`fwft_mode`=0), after a write into an empty FIFO, `r_flag` first reads 1 after the second rising `rclk` edge that follows the write edge.
- R3: In fall-through mode (`fwft_mode`=1), after a write into an empty FIFO, `r_flag` rises and `r_data` shows the word after the third rising `rclk` edge that follows the write edge. Without a read, the flag and the word then hold.
- R4: In standard mode, a read strobe while `r_flag` is 0 is ignored, and `r_data` keeps its old word.
- R5: In fall-through mode, once the shown word is consumed and no further word is stored, `r_flag` drops to 0. `r_data` keeps the consumed word, and read strobes are ignored while the flag is low.
- R6: With the default depth of 8 words, `w_flag` is 0 once 8 words are stored. A write attempted then is discarded and is never read out.
- R7: When a read frees a location in a full FIFO, `w_flag` returns to 1 after the second rising `wclk` edge that follows the read edge.
- R8: A read is accepted only when `r_sel`, `r_dir` and `r_en` are all 1. With any of them at 0, no word is taken.
- R9: Accepted words leave in the order they were accepted, including while both ports are active at once.
- R10: A write is accepted only when `w_sel`, `w_dir` and `w_en` are all 1 and `w_flag` is 1. With any strobe at 0, nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| arst_n | input | 1 | Asynchronous reset, active low, for both domains |
| fwft_mode | input | 1 | 1 = fall-through read mode, 0 = standard read mode; held while in reset |
| w_sel | input | 1 | Write-port select |
| w_dir | input | 1 | Write-port direction, 1 = write |
| w_en | input | 1 | Write-port enable |
| w_data | input | DATA_W | Word to store |
| w_flag | output | 1 | 1 = a location is free (input ready / not full) |
| r_sel | input | 1 | Read-port select |
| r_dir | input | 1 | Read-port direction, 1 = read |
| r_en | input | 1 | Read-port enable |
| r_data | output | DATA_W | Output register |
| r_flag | output | 1 | Fall-through: output ready; standard: not empty |

## Verification
Two pairs of events can land in the same cycle. In fall-through mode, the read side may consume the shown word on the same `rclk` edge that loads the next word. On the write side, a full FIFO may release a location just as a write is attempted. A fall-through stream is used to provoke both: writes come every 4 ns and reads every 6 ns, so the FIFO fills, stalls and refills while the reader drains it. A scoreboard judges the result. It holds every word whose strobe met a high `w_flag`, and each read taken while `r_flag` is high must return exactly the next word in that order.

// File: rtl/xclk_fifo_pkg.sv
`timescale 1ns/100ps
package xclk_fifo_pkg;
    typedef enum logic {
        RD_STD  = 1'b0,
        RD_FWFT = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/xclk_gray_sync.sv
`timescale 1ns/100ps
module xclk_gray_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/xclk_fifo_mem.sv
`timescale 1ns/100ps
module xclk_fifo_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/xclk_fifo_wside.sv
`timescale 1ns/100ps
module xclk_fifo_wside #(
    parameter int ADDR_W = 3,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              wclk,
    input  logic              arst_n,
    input  logic              w_sel,
    input  logic              w_dir,
    input  logic              w_en,
    input  logic [PTR_W-1:0]  rgray_s,
    output logic              w_flag,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [PTR_W-1:0]  wbin,
    output logic [PTR_W-1:0]  wgray
);
    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
    } wst_t;

    wst_t             s_d, s_q;
    logic             full;
    logic             accept;
    logic [PTR_W-1:0] nb;

    always_comb begin
        s_d    = s_q;
        full   = (s_q.gray == {~rgray_s[PTR_W-1:PTR_W-2], rgray_s[PTR_W-3:0]});
        accept = w_sel && w_dir && w_en && !full;
        nb     = s_q.bin + 1'b1;
        if (accept) begin
            s_d.bin  = nb;
            s_d.gray = nb ^ (nb >> 1);
        end
    end

    always_ff @(posedge wclk or negedge arst_n) begin
        if (!arst_n) s_q <= '0;
        else         s_q <= s_d;
    end

    assign w_flag = !full;
    assign we     = accept;
    assign waddr  = s_q.bin[ADDR_W-1:0];
    assign wbin   = s_q.bin;
    assign wgray  = s_q.gray;
endmodule

// File: rtl/xclk_fifo_rside.sv
`timescale 1ns/100ps
module xclk_fifo_rside
    import xclk_fifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              rclk,
    input  logic              arst_n,
    input  rd_mode_e          mode,
    input  logic              r_sel,
    input  logic              r_dir,
    input  logic              r_en,
    input  logic [PTR_W-1:0]  wgray_s,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] r_data,
    output logic              r_flag,
    output logic [PTR_W-1:0]  rbin,
    output logic [PTR_W-1:0]  rgray
);
    typedef struct packed {
        logic [PTR_W-1:0]  bin;
        logic [PTR_W-1:0]  gray;
        logic              shown;
        logic [DATA_W-1:0] dout;
    } rst_t;

    rst_t             s_d, s_q;
    logic             empty;
    logic             req;
    logic             take;
    logic [PTR_W-1:0] nb;

    always_comb begin
        s_d   = s_q;
        empty = (s_q.gray == wgray_s);
        req   = r_sel && r_dir && r_en;
        nb    = s_q.bin + 1'b1;
        if (mode == RD_FWFT) begin
            take = !empty && (!s_q.shown || req);
            if (req && s_q.shown && !take) begin
                s_d.shown = 1'b0;
            end
        end else begin
            take = req && !empty;
        end
        if (take) begin
            s_d.bin   = nb;
            s_d.gray  = nb ^ (nb >> 1);
            s_d.dout  = mem_rdata;
            s_d.shown = (mode == RD_FWFT);
        end
    end

    always_ff @(posedge rclk or negedge arst_n) begin
        if (!arst_n) s_q <= '0;
        else         s_q <= s_d;
    end

    assign raddr  = s_q.bin[ADDR_W-1:0];
    assign r_data = s_q.dout;
    assign r_flag = (mode == RD_FWFT) ? s_q.shown : !empty;
    assign rbin   = s_q.bin;
    assign rgray  = s_q.gray;
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/100ps
module xclk_fifo
    import xclk_fifo_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              arst_n,
    input  logic              fwft_mode,
    input  logic              w_sel,
    input  logic              w_dir,
    input  logic              w_en,
    input  logic [DATA_W-1:0] w_data,
    output logic              w_flag,
    input  logic              r_sel,
    input  logic              r_dir,
    input  logic              r_en,
    output logic [DATA_W-1:0] r_data,
    output logic              r_flag
);
    localparam int PTR_W = ADDR_W + 1;

    rd_mode_e          mode;
    logic              we;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [PTR_W-1:0]  wptr_bin, wptr_gray, rptr_bin, rptr_gray;
    logic [PTR_W-1:0]  wgray_rs, rgray_ws;

    assign mode = rd_mode_e'(fwft_mode);

    xclk_fifo_wside #(.ADDR_W(ADDR_W)) wside_i (
        .wclk(wclk), .arst_n(arst_n),
        .w_sel(w_sel), .w_dir(w_dir), .w_en(w_en),
        .rgray_s(rgray_ws), .w_flag(w_flag),
        .we(we), .waddr(waddr), .wbin(wptr_bin), .wgray(wptr_gray)
    );

    xclk_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(w_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    xclk_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) w2r_i (
        .clk(rclk), .arst_n(arst_n), .din(wptr_gray), .dout(wgray_rs)
    );

    xclk_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) r2w_i (
        .clk(wclk), .arst_n(arst_n), .din(rptr_gray), .dout(rgray_ws)
    );

    xclk_fifo_rside #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rside_i (
        .rclk(rclk), .arst_n(arst_n), .mode(mode),
        .r_sel(r_sel), .r_dir(r_dir), .r_en(r_en),
        .wgray_s(wgray_rs), .mem_rdata(mem_rdata), .raddr(raddr),
        .r_data(r_data), .r_flag(r_flag), .rbin(rptr_bin), .rgray(rptr_gray)
    );
endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/100ps
module xclk_fifo_chk #(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 4
) (
    input logic              wclk,
    input logic              rclk,
    input logic              arst_n,
    input logic              fwft_mode,
    input logic              w_sel,
    input logic              w_dir,
    input logic              w_en,
    input logic              w_flag,
    input logic              r_sel,
    input logic              r_dir,
    input logic              r_en,
    input logic [DATA_W-1:0] r_data,
    input logic              r_flag,
    input logic [PTR_W-1:0]  wptr,
    input logic [PTR_W-1:0]  rptr
);
    logic wreq, rreq;
    assign wreq = w_sel && w_dir && w_en;
    assign rreq = r_sel && r_dir && r_en;

    always @(posedge rclk) begin
        if (!arst_n) begin
            assert_rst_flags_R1: assert (!r_flag && w_flag);
        end
    end

    assert_std_ignore_R4: assert property (@(posedge rclk) disable iff (!arst_n)
        (!fwft_mode && !r_flag) |=> $stable(r_data));

    assert_fwft_keep_R3: assert property (@(posedge rclk) disable iff (!arst_n)
        (fwft_mode && r_flag && !rreq) |=> (r_flag && $stable(r_data)));

    assert_fwft_hold_R5: assert property (@(posedge rclk) disable iff (!arst_n)
        (fwft_mode && !r_flag) |=> (r_flag || $stable(r_data)));

    assert_no_overflow_R6: assert property (@(posedge wclk) disable iff (!arst_n)
        !w_flag |=> $stable(wptr));

    assert_read_qual_R8: assert property (@(posedge rclk) disable iff (!arst_n)
        (!fwft_mode && !rreq) |=> $stable(rptr));

    assert_write_qual_R10: assert property (@(posedge wclk) disable iff (!arst_n)
        !wreq |=> $stable(wptr));
endmodule

bind xclk_fifo xclk_fifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) chk_i (
    .wclk(wclk), .rclk(rclk), .arst_n(arst_n), .fwft_mode(fwft_mode),
    .w_sel(w_sel), .w_dir(w_dir), .w_en(w_en), .w_flag(w_flag),
    .r_sel(r_sel), .r_dir(r_dir), .r_en(r_en), .r_data(r_data), .r_flag(r_flag),
    .wptr(wptr_bin), .rptr(rptr_bin)
);

// File: tb/xclk_fifo_tb_top.sv
`timescale 1ns/100ps
module xclk_fifo_tb_top;
    localparam int DW = 16;

    logic          wclk, rclk, arst_n, fwft_mode;
    logic          w_sel, w_dir, w_en, w_flag;
    logic [DW-1:0] w_data;
    logic          r_sel, r_dir, r_en, r_flag;
    logic [DW-1:0] r_data;

    int            n_chk, n_fail, n_pop, n_push, cyc;
    logic [DW-1:0] sb_q [$];
    bit            pend;
    logic [DW-1:0] pend_val;

    xclk_fifo #(.DATA_W(DW), .ADDR_W(3), .SYNC_STAGES(2)) dut_i (
        .wclk(wclk), .rclk(rclk), .arst_n(arst_n), .fwft_mode(fwft_mode),
        .w_sel(w_sel), .w_dir(w_dir), .w_en(w_en), .w_data(w_data), .w_flag(w_flag),
        .r_sel(r_sel), .r_dir(r_dir), .r_en(r_en), .r_data(r_data), .r_flag(r_flag)
    );

    // wclk: 250 MHz, rising at 2+4k ns; rclk rising at 1+6k ns (never together)
    initial begin
        wclk = 0;
        forever #2 wclk = ~wclk;
    end
    initial begin
        rclk = 0;
        #1 rclk = 1;
        forever #3 rclk = ~rclk;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge wclk) begin
        cyc++;
        if (cyc > 50000) begin
            chk(1'b0, "watchdog", cyc, 50000);
            summary();
        end
    end

    // monitor: pops the scoreboard on every read taken while r_flag is high
    always @(negedge rclk) begin
        if (arst_n) begin
            if (pend) begin
                pend = 0;
                chk(r_data == pend_val, "R9 std read order", r_data, pend_val);
            end
            if (r_sel && r_dir && r_en && r_flag) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6/R9 word with no accepted write", r_data, 0);
                end else begin
                    n_pop++;
                    if (fwft_mode) begin
                        chk(r_data == sb_q[0], "R9 fwft read order", r_data, sb_q[0]);
                        void'(sb_q.pop_front());
                    end else begin
                        pend     = 1;
                        pend_val = sb_q.pop_front();
                    end
                end
            end
        end
    end

    task automatic wr(input int n, input logic [DW-1:0] base, input logic s, input logic d, input logic e);
        @(posedge wclk);
        #0.1;
        for (int i = 0; i < n; i++) begin
            w_data = base + DW'(i);
            w_sel = s; w_dir = d; w_en = e;
            if (s && d && e && w_flag) begin
                sb_q.push_back(w_data);
                n_push++;
            end
            @(posedge wclk);
            #0.1;
        end
        w_sel = 0; w_dir = 0; w_en = 0;
    endtask

    task automatic rd(input int n, input logic s, input logic d, input logic e);
        @(posedge rclk);
        #0.1;
        r_sel = s; r_dir = d; r_en = e;
        repeat (n) @(posedge rclk);
        #0.1;
        r_sel = 0; r_dir = 0; r_en = 0;
    endtask

    task automatic do_reset(input logic mode);
        arst_n = 0;
        fwft_mode = mode;
        w_sel = 0; w_dir = 0; w_en = 0; w_data = '0;
        r_sel = 0; r_dir = 0; r_en = 0;
        sb_q.delete();
        pend = 0;
        #20;
        chk(r_flag == 1'b0, "R1 r_flag in reset", r_flag, 0);
        chk(w_flag == 1'b1, "R1 w_flag in reset", w_flag, 1);
        @(posedge rclk);
        #0.5;
        arst_n = 1;
    endtask

    task automatic count_rclk_to_flag(output int n);
        n = 0;
        while (n < 10) begin
            @(posedge rclk);
            #0.5;
            n++;
            if (r_flag) break;
        end
    endtask

    initial begin
        int n;
        int p0;
        n_chk = 0; n_fail = 0; n_pop = 0; n_push = 0; cyc = 0;

        // ---------------- standard mode ----------------
        do_reset(1'b0);
        wr(1, 16'h1111, 1, 1, 1);
        count_rclk_to_flag(n);
        chk(n == 2, "R2 empty flag latency (rclk edges)", n, 2);

        // partial read strobes: nothing taken
        rd(1, 1, 0, 1);
        rd(1, 1, 1, 0);
        rd(1, 0, 1, 1);
        #0.4;
        chk(r_flag == 1'b1, "R8 partial read leaves word", r_flag, 1);
        chk(r_data == 16'h0000, "R8 partial read leaves r_data", r_data, 0);
        rd(1, 1, 1, 1);
        #0.4;
        chk(r_data == 16'h1111, "R9 std read data", r_data, 16'h1111);
        @(posedge rclk);
        #0.5;
        chk(r_flag == 1'b0, "R4 flag low after last word", r_flag, 0);
        rd(2, 1, 1, 1);
        #0.4;
        chk(r_data == 16'h1111, "R4 read while empty keeps r_data", r_data, 16'h1111);

        // partial write strobes: nothing stored
        wr(2, 16'h2200, 1, 1, 0);
        wr(2, 16'h2300, 0, 1, 1);
        wr(2, 16'h2400, 1, 0, 1);
        repeat (5) @(posedge rclk);
        #0.5;
        chk(r_flag == 1'b0, "R10 partial write stores nothing", r_flag, 0);

        // fill to depth 8, overflow attempt, release timing
        wr(8, 16'h3000, 1, 1, 1);
        chk(w_flag == 1'b0, "R6 w_flag low at 8 words", w_flag, 0);
        chk(sb_q.size() == 8, "R6 eight words accepted", sb_q.size(), 8);
        wr(1, 16'hDEAD, 1, 1, 1);
        chk(sb_q.size() == 8, "R6 write while full discarded", sb_q.size(), 8);
        repeat (3) @(posedge rclk);
        rd(1, 1, 1, 1);
        n = 0;
        while (n < 10) begin
            @(posedge wclk);
            #0.5;
            n++;
            if (w_flag) break;
        end
        chk(n == 2, "R7 w_flag release latency (wclk edges)", n, 2);
        rd(12, 1, 1, 1);
        #1;
        chk(sb_q.size() == 0 && !pend, "R9 std drain complete", sb_q.size(), 0);
        chk(r_flag == 1'b0, "R6 no extra word after drain", r_flag, 0);

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        wr(1, 16'hA5A5, 1, 1, 1);
        count_rclk_to_flag(n);
        chk(n == 3, "R3 output ready latency (rclk edges)", n, 3);
        chk(r_data == 16'hA5A5, "R3 word shown with flag", r_data, 16'hA5A5);
        repeat (3) @(posedge rclk);
        #0.5;
        chk(r_flag && r_data == 16'hA5A5, "R3 word held without read", r_data, 16'hA5A5);
        rd(1, 1, 1, 1);
        #0.4;
        chk(r_flag == 1'b0, "R5 flag low after consume", r_flag, 0);
        chk(r_data == 16'hA5A5, "R5 consumed word stays", r_data, 16'hA5A5);
        rd(2, 1, 1, 1);
        #0.4;
        chk(r_data == 16'hA5A5 && !r_flag, "R5 read while low ignored", r_data, 16'hA5A5);

        // concurrent stream: writer outpaces reader, FIFO fills and drains
        p0 = n_pop;
        n_push = 0;
        fork
            wr(24, 16'h0100, 1, 1, 1);
            rd(60, 1, 1, 1);
        join
        #1;
        chk(n_pop - p0 == n_push, "R9 stream pops equal pushes", n_pop - p0, n_push);
        chk(sb_q.size() == 0, "R9 stream scoreboard empty", sb_q.size(), 0);
        chk(n_push < 24, "R6 stream hit full at least once", n_push, 23);

        summary();
    end
endmodule